// File: doc/BRIEF.md
# Load-Use Interlock for a Nine-Stage In-Order Pipeline

This block decides, every cycle, whether the instruction sitting in the second decode stage may move on to register read. The pipeline runs two fetch stages, two decode stages, register read, ALU, two data-memory stages and register write. The block looks at the five stages from register read to register write. For each stage it receives a valid bit, a write enable, a load flag and a destination register number, and it compares these against the two source register numbers of the decoding instruction. If an operand cannot yet be obtained, the block raises a combinational stall that freezes the decode stage and everything in front of it. It also raises a bubble request so that register read receives an empty slot. Stages from register read onward always advance.

A non-load result is ready at the end of the ALU stage and is written to the register file in the slot right after it. A load result is ready only after both memory stages and is written in the register write slot. A parameter selects one of two datapaths. In the first there is no forwarding, and an operand is readable only in the cycle after its write. In the second the ALU input can take the ALU result register or the load-data register, and the register file passes a same-cycle write through to its read port. For that variant the block also produces a forwarding select for each operand. The select is timed for the cycle in which the consumer occupies the ALU stage.

Top module: `lui_interlock`

## Requirements
- R1: Without forwarding, a load immediately followed by an instruction reading the loaded register stalls that instruction for exactly 4 cycles.
- R2: With forwarding, the same adjacent load-use pair stalls for exactly 2 cycles.
- R3: A non-load producer immediately followed by a reader causes 2 stall cycles without forwarding and none with forwarding.
- R4: Each independent instruction placed between producer and consumer removes one stall cycle, down to zero: a load costs max(0, 5-d) cycles without forwarding and max(0, 3-d) with it, where d is the distance in instructions (adjacent is 1).
- R5: A source register number of 0 never produces a stall or a forwarding select.
- R6: A back stage takes part in the comparison only when both its valid bit and its write enable are 1; the destination and load flag of any other stage have no effect.
- R7: When several in-flight instructions write the same register, only the youngest (the one nearest register read) decides the stall and the forwarding source.
- R8: The stall output is combinational. It is 1 in exactly those cycles in which a valid decode instruction would read a stale operand, it falls in the first cycle the operand is obtainable, and it is 0 whenever the decode slot is empty.
- R9: The bubble output is 1 when the stall is 1 or the decode slot is empty, and 0 otherwise.
- R10: Each forwarding select is 1 (ALU result register, stage after ALU) or 2 (load-data register, write stage) in the cycle the consumer is in the ALU stage, two cycles after leaving decode. It is 0 (register file) at all other times, and always 0 without forwarding.
- R11: For any instruction sequence, the cycles from the first instruction leaving decode to the last one leaving decode, inclusive, equal the instruction count plus the stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Second decode stage holds an instruction |
| dec_src_a | input | REG_AW | First source register of the decode instruction |
| dec_src_b | input | REG_AW | Second source register of the decode instruction |
| bk_valid | input | 5 | Valid bit per back stage (bit 0 register read, 1 ALU, 2 first memory, 3 second memory, 4 write) |
| bk_wen | input | 5 | Register-write enable per back stage |
| bk_load | input | 5 | Load flag per back stage |
| bk_dst | input | 5 x REG_AW | Destination register per back stage |
| stall | output | 1 | Hold the decode stage and the stages before it |
| bubble | output | 1 | Insert an empty slot into register read |
| fwd_sel_a | output | 2 | ALU-input source for operand A (0 register file, 1 ALU result, 2 load data) |
| fwd_sel_b | output | 2 | ALU-input source for operand B |

## Verification
The assertions take three things for granted about the inputs. The back-stage inputs shift by exactly one stage per clock. The decode stage keeps the same sources while the stall is high. No non-load writes a register that an older load still in flight will also write, because the block does not order such writes. The bench builds every cycle's back-stage contents from departure times it computes itself. That keeps the shifting and holding exact. Random sequences draw load destinations and non-load destinations from disjoint register pools. Empty stages carry garbage destinations with write enable and load flag set, so that any leak through an invalid stage shows up.

// File: rtl/lui_pkg.sv
package lui_pkg;

   // Back stages, youngest first: register read, ALU, mem 1, mem 2, write.
   localparam int NUM_BACK = 5;
   localparam int STW      = 3;

   localparam logic [STW-1:0] ST_RR = 3'd0;
   localparam logic [STW-1:0] ST_AL = 3'd1;
   localparam logic [STW-1:0] ST_M1 = 3'd2;
   localparam logic [STW-1:0] ST_M2 = 3'd3;
   localparam logic [STW-1:0] ST_RW = 3'd4;

   typedef enum logic [1:0] {
      FWD_RF  = 2'd0,
      FWD_ALU = 2'd1,
      FWD_MEM = 2'd2
   } fwd_e;

   typedef struct packed {
      logic           hit;
      logic           is_load;
      logic [STW-1:0] stage;
   } prod_t;

endpackage

// File: rtl/lui_match.sv
module lui_match
   import lui_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0]                 src,
   input  logic [NUM_BACK-1:0]               bk_valid,
   input  logic [NUM_BACK-1:0]               bk_wen,
   input  logic [NUM_BACK-1:0]               bk_load,
   input  logic [NUM_BACK-1:0][REG_AW-1:0]   bk_dst,
   output prod_t                             prod
);

   logic [NUM_BACK-1:0] hit_vec;
   logic                src_live;

   assign src_live = (src != '0);

   for (genvar k = 0; k < NUM_BACK; k++) begin : g_cmp
      assign hit_vec[k] = src_live & bk_valid[k] & bk_wen[k] &
                          (bk_dst[k] == src);
   end

   // Lowest index is the youngest writer; scanning downward lets it win.
   always_comb begin
      prod = '0;
      for (int k = NUM_BACK - 1; k >= 0; k--) begin
         if (hit_vec[k]) begin
            prod.hit     = 1'b1;
            prod.is_load = bk_load[k];
            prod.stage   = STW'(k);
         end
      end
   end

endmodule

// File: rtl/lui_policy.sv
module lui_policy
   import lui_pkg::*;
#(
   parameter bit BYPASS = 1'b1
) (
   input  prod_t prod,
   output logic  hold,
   output fwd_e  sel
);

   if (BYPASS) begin : g_fwd
      // Load data is usable at the ALU input once the load reached mem 1
      // at departure; a non-load in register read is taken from the
      // ALU result register, later ones via write-through.
      always_comb begin
         hold = prod.hit & prod.is_load & (prod.stage <= ST_AL);
         sel  = FWD_RF;
         if (prod.hit && !prod.is_load && prod.stage == ST_RR)
            sel = FWD_ALU;
         else if (prod.hit && prod.is_load && prod.stage == ST_M1)
            sel = FWD_MEM;
      end
   end else begin : g_nofwd
      // Operand readable only the cycle after its register-file write:
      // non-loads write in mem 1, loads in the write stage.
      always_comb begin
         if (prod.is_load)
            hold = prod.hit & (prod.stage <= ST_M2);
         else
            hold = prod.hit & (prod.stage <= ST_AL);
         sel  = FWD_RF;
      end
   end

endmodule

// File: rtl/lui_fwd_pipe.sv
module lui_fwd_pipe
   import lui_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  fwd_e sel_a_in,
   input  fwd_e sel_b_in,
   output fwd_e sel_a_al,
   output fwd_e sel_b_al
);

   fwd_e sel_a_rr, sel_b_rr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_a_rr <= FWD_RF;
         sel_b_rr <= FWD_RF;
         sel_a_al <= FWD_RF;
         sel_b_al <= FWD_RF;
      end else begin
         sel_a_rr <= launch ? sel_a_in : FWD_RF;
         sel_b_rr <= launch ? sel_b_in : FWD_RF;
         sel_a_al <= sel_a_rr;
         sel_b_al <= sel_b_rr;
      end
   end

   // R10: a slot that did not leave decode two cycles ago never forwards.
   a_r10_idle_slot_rf : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(launch, 2) |-> (sel_a_al == FWD_RF && sel_b_al == FWD_RF));

endmodule

// File: rtl/lui_interlock.sv
module lui_interlock
   import lui_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter bit BYPASS = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               dec_valid,
   input  logic [REG_AW-1:0]                  dec_src_a,
   input  logic [REG_AW-1:0]                  dec_src_b,
   input  logic [NUM_BACK-1:0]                bk_valid,
   input  logic [NUM_BACK-1:0]                bk_wen,
   input  logic [NUM_BACK-1:0]                bk_load,
   input  logic [NUM_BACK-1:0][REG_AW-1:0]    bk_dst,
   output logic                               stall,
   output logic                               bubble,
   output logic [1:0]                         fwd_sel_a,
   output logic [1:0]                         fwd_sel_b
);

   localparam int MAX_STALL = BYPASS ? 2 : 4;
   localparam int RUN_W     = 3;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("lui_interlock: REG_AW must lie in 1..8");
   end

   prod_t prod_a, prod_b;
   logic  hold_a, hold_b, launch;
   fwd_e  sel_a_dec, sel_b_dec, sel_a_al, sel_b_al;

   lui_match #(.REG_AW(REG_AW)) i_match_a (
      .src(dec_src_a), .bk_valid(bk_valid), .bk_wen(bk_wen),
      .bk_load(bk_load), .bk_dst(bk_dst), .prod(prod_a));

   lui_match #(.REG_AW(REG_AW)) i_match_b (
      .src(dec_src_b), .bk_valid(bk_valid), .bk_wen(bk_wen),
      .bk_load(bk_load), .bk_dst(bk_dst), .prod(prod_b));

   lui_policy #(.BYPASS(BYPASS)) i_policy_a (
      .prod(prod_a), .hold(hold_a), .sel(sel_a_dec));

   lui_policy #(.BYPASS(BYPASS)) i_policy_b (
      .prod(prod_b), .hold(hold_b), .sel(sel_b_dec));

   assign stall  = dec_valid & (hold_a | hold_b);
   assign bubble = stall | ~dec_valid;
   assign launch = dec_valid & ~stall;

   lui_fwd_pipe i_fwd_pipe (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .sel_a_in(sel_a_dec), .sel_b_in(sel_b_dec),
      .sel_a_al(sel_a_al), .sel_b_al(sel_b_al));

   assign fwd_sel_a = sel_a_al;
   assign fwd_sel_b = sel_b_al;

   // Consecutive-stall run length, used only by the checks below.
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (stall && run_q != '1)
         run_q <= run_q + 1'b1;
      else if (!stall)
         run_q <= '0;
   end

   // R1 / R2: no dependence holds decode longer than the load latency.
   a_r2_stall_bound : assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(MAX_STALL));

   // R5: register 0 sources never hold decode.
   a_r5_zero_src : assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_a == '0 && dec_src_b == '0) |-> !stall);

   // R6: with no writing stage in flight nothing can stall.
   a_r6_no_writer : assert property (@(posedge clk) disable iff (!rst_n)
      ((bk_valid & bk_wen) == '0) |-> !stall);

   // R8 / R9: an empty decode slot never stalls and always bubbles.
   a_r9_empty_slot : assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (bubble && !stall));

   // R9: a stall always comes with a bubble.
   a_r9_stall_bubble : assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> bubble);

   if (!BYPASS) begin : g_chk_nofwd
      // R10: without forwarding the selects stay on the register file.
      a_r10_no_fwd : assert property (@(posedge clk) disable iff (!rst_n)
         (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));
   end else begin : g_chk_fwd
      // R10: code 3 is never produced.
      a_r10_legal_code : assert property (@(posedge clk) disable iff (!rst_n)
         (fwd_sel_a != 2'd3 && fwd_sel_b != 2'd3));
   end

endmodule

// File: tb/test_lui_interlock.sv
module test_lui_interlock;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 5;
   localparam int NB         = 5;
   localparam int WD_LIMIT   = 150000;
   localparam int MAXI       = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // index 0: no forwarding, index 1: forwarding
   logic                 dv [2];
   logic [AW-1:0]        sa [2];
   logic [AW-1:0]        sb [2];
   logic [NB-1:0]        bv [2];
   logic [NB-1:0]        bw [2];
   logic [NB-1:0]        bl [2];
   logic [NB-1:0][AW-1:0] bd [2];
   logic                 st [2];
   logic                 bu [2];
   logic [1:0]           fa [2];
   logic [1:0]           fb [2];

   lui_interlock #(.REG_AW(AW), .BYPASS(1'b1)) i_lui_interlock (
      .clk(clk), .rst_n(rst_n), .dec_valid(dv[1]), .dec_src_a(sa[1]),
      .dec_src_b(sb[1]), .bk_valid(bv[1]), .bk_wen(bw[1]), .bk_load(bl[1]),
      .bk_dst(bd[1]), .stall(st[1]), .bubble(bu[1]),
      .fwd_sel_a(fa[1]), .fwd_sel_b(fb[1]));

   lui_interlock #(.REG_AW(AW), .BYPASS(1'b0)) i_lui_interlock_nb (
      .clk(clk), .rst_n(rst_n), .dec_valid(dv[0]), .dec_src_a(sa[0]),
      .dec_src_b(sb[0]), .bk_valid(bv[0]), .bk_wen(bw[0]), .bk_load(bl[0]),
      .bk_dst(bd[0]), .stall(st[0]), .bubble(bu[0]),
      .fwd_sel_a(fa[0]), .fwd_sel_b(fb[0]));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   int p_ld [MAXI], p_wn [MAXI], p_dst [MAXI], p_sa [MAXI], p_sb [MAXI];
   int tl [MAXI], ya [MAXI], yb [MAXI], es_a [MAXI], es_b [MAXI];
   int pn;
   int seed = 32'h1d2c3b4a;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic idle(int m);
      dv[m] = 1'b0; sa[m] = '0; sb[m] = '0;
      bv[m] = '0; bw[m] = '0; bl[m] = '0; bd[m] = '0;
   endtask

   task automatic add(int ld, int wn, int dst, int a, int b);
      p_ld[pn] = ld; p_wn[pn] = wn; p_dst[pn] = dst;
      p_sa[pn] = a;  p_sb[pn] = b;
      pn++;
   endtask

   function automatic int youngest(int i, int src);
      int y;
      y = -1;
      if (src != 0)
         for (int j = i - 1; j >= 0; j--)
            if (y < 0 && p_wn[j] != 0 && p_dst[j] == src) y = j;
      return y;
   endfunction

   function automatic int need(int m, int y);
      int thr;
      if (p_ld[y] != 0) thr = (m != 0) ? 2 : 4;
      else              thr = (m != 0) ? 0 : 2;
      return tl[y] + 1 + thr;
   endfunction

   function automatic int code(int m, int i, int y);
      int k;
      if (m == 0 || y < 0) return 0;
      k = tl[i] - tl[y] - 1;
      if (p_ld[y] != 0) return (k == 2) ? 2 : 0;
      return (k == 0) ? 1 : 0;
   endfunction

   // Departure cycle of each instruction from decode, from the thresholds.
   task automatic plan_times(int m);
      for (int i = 0; i < pn; i++) begin
         int t;
         t = (i == 0) ? 0 : tl[i-1] + 1;
         ya[i] = youngest(i, p_sa[i]);
         yb[i] = youngest(i, p_sb[i]);
         if (ya[i] >= 0 && need(m, ya[i]) > t) t = need(m, ya[i]);
         if (yb[i] >= 0 && need(m, yb[i]) > t) t = need(m, yb[i]);
         tl[i] = t;
         es_a[i] = code(m, i, ya[i]);
         es_b[i] = code(m, i, yb[i]);
      end
   endtask

   task automatic run_prog(int m, string tag, int exp_st);
      int last, obs;
      plan_times(m);
      last = tl[pn-1];
      obs = 0;
      for (int c = 0; c <= last + 4; c++) begin
         int di, ai, ea, eb, es;
         @(negedge clk);
         di = -1;
         for (int i = 0; i < pn; i++)
            if (((i == 0) ? -1 : tl[i-1]) < c && c <= tl[i]) di = i;
         if (di >= 0) begin
            dv[m] = 1'b1; sa[m] = AW'(p_sa[di]); sb[m] = AW'(p_sb[di]);
         end else begin
            dv[m] = 1'b0; sa[m] = AW'(c % 7); sb[m] = AW'((c + 3) % 7);
         end
         for (int k = 0; k < NB; k++) begin
            bv[m][k] = 1'b0; bw[m][k] = 1'b1; bl[m][k] = 1'b1;
            bd[m][k] = AW'((c + k) % 7);
            for (int j = 0; j < pn; j++)
               if (tl[j] + 1 + k == c) begin
                  bv[m][k] = 1'b1;
                  bw[m][k] = (p_wn[j] != 0);
                  bl[m][k] = (p_ld[j] != 0);
                  bd[m][k] = AW'(p_dst[j]);
               end
         end
         #1;
         es = (di >= 0 && c < tl[di]) ? 1 : 0;
         chk("R8", "stall", int'(st[m]), es);
         chk("R9", "bubble", int'(bu[m]), (es != 0 || di < 0) ? 1 : 0);
         ai = -1;
         for (int i = 0; i < pn; i++) if (tl[i] + 2 == c) ai = i;
         ea = (ai >= 0) ? es_a[ai] : 0;
         eb = (ai >= 0) ? es_b[ai] : 0;
         chk("R10", "fwd_sel_a", int'(fa[m]), ea);
         chk("R10", "fwd_sel_b", int'(fb[m]), eb);
         if (st[m]) obs++;
      end
      if (exp_st >= 0) chk(tag, "stall cycles", obs, exp_st);
      chk("R11", "total cycles", last + 1, pn + obs);
      idle(m);
   endtask

   task automatic both(string tag, int e0, int e1);
      run_prog(0, tag, e0);
      run_prog(1, tag, e1);
   endtask

   function automatic int rnd(int mod);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fffff) % mod;
   endfunction

   initial begin
      idle(0); idle(1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: R8 and R10
      chk("R8", "stall in reset", int'(st[1]), 0);
      chk("R10", "sel a in reset", int'(fa[1]), 0);
      chk("R10", "sel b in reset nb", int'(fb[0]), 0);
      rst_n = 1'b1;

      // R1 / R2: adjacent load-use, operand A then operand B
      pn = 0; add(1, 1, 5, 0, 0); add(0, 1, 9, 5, 0); both("R1", 4, 2);
      pn = 0; add(1, 1, 5, 0, 0); add(0, 1, 9, 3, 5); both("R2", 4, 2);
      // R3: adjacent non-load producer
      pn = 0; add(0, 1, 5, 0, 0); add(0, 1, 9, 5, 5); both("R3", 2, 0);
      // R4: intervening independent instructions
      pn = 0; add(1, 1, 5, 0, 0); add(0, 0, 0, 0, 0); add(0, 1, 9, 5, 0);
      both("R4", 3, 1);
      pn = 0; add(1, 1, 5, 0, 0); add(0, 0, 0, 0, 0); add(0, 0, 0, 0, 0);
      add(0, 1, 9, 0, 5); both("R4", 2, 0);
      pn = 0; add(1, 1, 5, 0, 0);
      for (int i = 0; i < 4; i++) add(0, 0, 0, 0, 0);
      add(0, 1, 9, 5, 0); both("R4", 0, 0);
      pn = 0; add(0, 1, 5, 0, 0); add(0, 0, 0, 0, 0); add(0, 1, 9, 5, 0);
      both("R4", 1, 0);
      // R5: register 0
      pn = 0; add(1, 1, 0, 0, 0); add(0, 1, 9, 0, 0); both("R5", 0, 0);
      // R6: producer without write enable
      pn = 0; add(1, 0, 5, 0, 0); add(0, 1, 9, 5, 5); both("R6", 0, 0);
      // R7: two writers of r5, youngest decides stall and source
      pn = 0; add(0, 1, 5, 0, 0); add(0, 1, 5, 0, 0); add(0, 1, 9, 5, 0);
      both("R7", 2, 0);
      pn = 0; add(1, 1, 5, 0, 0); add(1, 1, 5, 0, 0); add(0, 1, 9, 0, 5);
      both("R7", 4, 2);

      // near-exhaustive random sequences over a small register set
      for (int r = 0; r < 60; r++) begin
         pn = 0;
         for (int i = 0; i < 12; i++) begin
            int ld;
            ld = (rnd(3) == 0) ? 1 : 0;
            add(ld, (rnd(5) != 0) ? 1 : 0,
                (ld != 0) ? 1 + rnd(3) : 4 + rnd(3), rnd(7), rnd(7));
         end
         both("R4", -1, -1);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cyc >= WD_LIMIT);
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule